// File: doc/BRIEF.md
# SD Host Interrupt Status Registers

This block keeps the interrupt-facing status of an SD host controller. The command engine, the data engine and the card socket report events to it as single-cycle pulses or as levels. The block latches the events as sticky flags in two 32-bit status words and shows a few live levels next to them in the same words. It drives one interrupt line, which is the OR of every sticky flag that its mask bit does not block. Software reads the words over a simple register bus and clears a flag by writing a zero to its bit.

The two buffer-ready flags are set on the rising edge of their condition and not on its level. A flag cleared while its condition is still true therefore stays clear until the condition falls and rises again. The raw card-detect pin passes through a two-flop synchroniser and a debounce state machine. An accepted rising level raises the "inserted" flag and an accepted falling level raises the "removed" flag.

The debounce machine has four states. IDLE_OUT means the card is absent and stable. CHK_IN counts a candidate insertion. SEATED means the card is present and stable. CHK_OUT counts a candidate removal. The transitions are as follows. IDLE_OUT goes to CHK_IN when the synchronised pin is high. CHK_IN goes back to IDLE_OUT when the pin drops before the count completes, and to SEATED when the count completes, which emits the insert event. SEATED goes to CHK_OUT when the pin is low. CHK_OUT goes back to SEATED when the pin rises before the count completes, and to IDLE_OUT when the count completes, which emits the remove event.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset every sticky flag reads 0, both mask words read 32'hFFFF_FFFF and `irq` is 0.
- R2: Word addresses are 0 for status A, 1 for mask A, 2 for status B and 3 for mask B. Status A has bit 0 response done, bit 2 data done, bit 3 card removed, bit 4 card inserted and bit 5 the live debounced card-present level. Every other bit of status A reads 0.
- R3: Status B bits 0 to 6 latch `err_evt[0]` to `err_evt[6]` (index, CRC, end bit, data timeout, illegal write, illegal read, response timeout). Bit 7 shows `dat0_lvl` live, bit 8 is read-buffer ready, bit 9 is write-buffer ready, bit 14 shows `cmd_busy` live and bit 15 is illegal access. Every other bit reads 0.
- R4: An event pulse sampled at a clock edge sets its flag, and the flag is readable after that edge. Writing 0 to a sticky bit clears it at the write edge. Writing 1 leaves it unchanged.
- R5: Live bits ignore writes and always show their source level.
- R6: When a set pulse and a clearing write hit the same bit at the same edge, the bit ends set.
- R7: A buffer-ready flag is set only on a 0-to-1 transition of its level input. Cleared while the level stays 1, it stays 0. It sets again after the level falls and rises.
- R8: `irq` is 1 exactly when some sticky flag is 1 and its mask bit is 0. A mask bit of 1 blocks its flag.
- R9: `cd_raw` passes through two synchronising flops and must then hold for DEBOUNCE cycles. With the default of 4, a rise that lasts takes effect 7 clock edges after it is applied: the inserted flag and the live level go to 1 at that edge. A fall takes effect in the same way with the removed flag. A pulse shorter than the window leaves everything unchanged.
- R10: Both mask words hold all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_rsp_done | input | 1 | Response complete pulse |
| evt_data_done | input | 1 | Data complete pulse |
| err_evt | input | 7 | Error pulses, bit i goes to status B bit i |
| evt_ill_access | input | 1 | Illegal access pulse |
| rbuf_rdy | input | 1 | Read buffer ready level |
| wbuf_rdy | input | 1 | Write buffer ready level |
| dat0_lvl | input | 1 | DAT0 line level |
| cmd_busy | input | 1 | Command busy level |
| cd_raw | input | 1 | Asynchronous card-detect pin |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational. A flag or a clear becomes visible, together with its effect on `irq`, right after the single clock edge that samples the pulse or the write. The bench drives inputs at the falling edge, lets exactly one rising edge pass and samples at the next falling edge. The card-detect path has its own timing: seven edges after a lasting change. The bench checks that the flag is still 0 after the sixth edge and is 1 after the seventh. Glitches of three cycles are shown to change nothing.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int DW   = 32;
    localparam int NERR = 7;

    typedef enum logic [1:0] {
        AD_STAT_A = 2'd0,
        AD_MASK_A = 2'd1,
        AD_STAT_B = 2'd2,
        AD_MASK_B = 2'd3
    } reg_word_e;

    localparam int A_RSP  = 0;
    localparam int A_DATA = 2;
    localparam int A_REM  = 3;
    localparam int A_INS  = 4;
    localparam int A_CD   = 5;

    localparam int B_DAT0 = 7;
    localparam int B_RBUF = 8;
    localparam int B_WBUF = 9;
    localparam int B_BUSY = 14;
    localparam int B_ILA  = 15;

    localparam logic [DW-1:0] A_STICKY = 32'h0000_001D;
    localparam logic [DW-1:0] A_LIVE   = 32'h0000_0020;
    localparam logic [DW-1:0] B_STICKY = 32'h0000_837F;
    localparam logic [DW-1:0] B_LIVE   = 32'h0000_4080;
endpackage

// File: rtl/sdh_sticky_reg.sv
module sdh_sticky_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] STICKY = '0,
    parameter logic [W-1:0] LIVE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    input  logic [W-1:0] live,
    output logic [W-1:0] q,
    output logic [W-1:0] value
);
    logic [W-1:0] keep;

    always_comb keep = wr ? wdata : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & keep) | set) & STICKY;
    end

    always_comb value = (q & STICKY) | (live & LIVE);
endmodule

// File: rtl/sdh_edge_det.sv
module sdh_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= 1'b0;
            else        prev[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev[i];
    end
endmodule

// File: rtl/sdh_cd_filter.sv
module sdh_cd_filter #(
    parameter int DEBOUNCE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_raw,
    output logic present,
    output logic ins_evt,
    output logic rem_evt
);
    localparam int CW = (DEBOUNCE > 1) ? $clog2(DEBOUNCE) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

    typedef enum logic [1:0] {IDLE_OUT, CHK_IN, SEATED, CHK_OUT} cd_state_e;

    cd_state_e state, nstate;
    logic [CW-1:0] cnt, ncnt;
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= cd_raw;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= IDLE_OUT;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        unique case (state)
            IDLE_OUT: if (s2) begin nstate = CHK_IN; ncnt = '0; end
            CHK_IN: begin
                if (!s2)              nstate = IDLE_OUT;
                else if (cnt == LAST) nstate = SEATED;
                else                  ncnt = cnt + 1'b1;
            end
            SEATED: if (!s2) begin nstate = CHK_OUT; ncnt = '0; end
            CHK_OUT: begin
                if (s2)               nstate = SEATED;
                else if (cnt == LAST) nstate = IDLE_OUT;
                else                  ncnt = cnt + 1'b1;
            end
        endcase
    end

    always_comb begin
        present = (state == SEATED) || (state == CHK_OUT);
        ins_evt = (state == CHK_IN)  && s2  && (cnt == LAST);
        rem_evt = (state == CHK_OUT) && !s2 && (cnt == LAST);
    end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int DEBOUNCE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            evt_rsp_done,
    input  logic            evt_data_done,
    input  logic [NERR-1:0] err_evt,
    input  logic            evt_ill_access,
    input  logic            rbuf_rdy,
    input  logic            wbuf_rdy,
    input  logic            dat0_lvl,
    input  logic            cmd_busy,
    input  logic            cd_raw,
    output logic            irq
);
    reg_word_e word;
    logic [DW-1:0] set_a, set_b, live_a, live_b;
    logic [DW-1:0] stat_a_q, stat_b_q, val_a, val_b;
    logic [DW-1:0] mask_a_q, mask_b_q;
    logic [1:0] buf_rise;
    logic cd_present, cd_ins, cd_rem;

    assign word = reg_word_e'(reg_addr);

    sdh_cd_filter #(.DEBOUNCE(DEBOUNCE)) u_cd (
        .clk(clk), .rst_n(rst_n), .cd_raw(cd_raw),
        .present(cd_present), .ins_evt(cd_ins), .rem_evt(cd_rem)
    );

    sdh_edge_det #(.N(2)) u_buf (
        .clk(clk), .rst_n(rst_n), .lvl({wbuf_rdy, rbuf_rdy}), .rise(buf_rise)
    );

    always_comb begin
        set_a = '0;
        set_a[A_RSP]  = evt_rsp_done;
        set_a[A_DATA] = evt_data_done;
        set_a[A_REM]  = cd_rem;
        set_a[A_INS]  = cd_ins;
        live_a = '0;
        live_a[A_CD] = cd_present;

        set_b = '0;
        set_b[NERR-1:0] = err_evt;
        set_b[B_RBUF]   = buf_rise[0];
        set_b[B_WBUF]   = buf_rise[1];
        set_b[B_ILA]    = evt_ill_access;
        live_b = '0;
        live_b[B_DAT0] = dat0_lvl;
        live_b[B_BUSY] = cmd_busy;
    end

    sdh_sticky_reg #(.W(DW), .STICKY(A_STICKY), .LIVE(A_LIVE)) u_stat_a (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr && word == AD_STAT_A),
        .wdata(reg_wdata), .set(set_a), .live(live_a),
        .q(stat_a_q), .value(val_a)
    );

    sdh_sticky_reg #(.W(DW), .STICKY(B_STICKY), .LIVE(B_LIVE)) u_stat_b (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr && word == AD_STAT_B),
        .wdata(reg_wdata), .set(set_b), .live(live_b),
        .q(stat_b_q), .value(val_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a_q <= '1;
            mask_b_q <= '1;
        end else if (reg_wr) begin
            if (word == AD_MASK_A) mask_a_q <= reg_wdata;
            if (word == AD_MASK_B) mask_b_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (word)
            AD_STAT_A: reg_rdata = val_a;
            AD_MASK_A: reg_rdata = mask_a_q;
            AD_STAT_B: reg_rdata = val_b;
            AD_MASK_B: reg_rdata = mask_b_q;
        endcase
    end

    always_comb irq = |(stat_a_q & ~mask_a_q) | |(stat_b_q & ~mask_b_q);
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        wdata0,
    input logic        evt_rsp_done,
    input logic        rbuf_rdy,
    input logic        stat_a0,
    input logic        stat_b_rbuf,
    input logic [31:0] mask_a_q,
    input logic [31:0] mask_b_q,
    input logic        irq,
    input logic        cd_ins,
    input logic        cd_rem
);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && !wdata0 && !evt_rsp_done) |=> !stat_a0);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rsp_done |=> stat_a0);

    p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rbuf_rdy) && rbuf_rdy && !stat_b_rbuf) |=> !stat_b_rbuf);

    p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_a_q && &mask_b_q) |-> !irq);

    p_cd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cd_ins, cd_rem}));
endmodule

bind sdh_irq_status sdh_irq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata0(reg_wdata[0]), .evt_rsp_done(evt_rsp_done), .rbuf_rdy(rbuf_rdy),
    .stat_a0(stat_a_q[0]), .stat_b_rbuf(stat_b_q[8]),
    .mask_a_q(mask_a_q), .mask_b_q(mask_b_q), .irq(irq),
    .cd_ins(cd_ins), .cd_rem(cd_rem)
);

// File: tb/sdh_irq_status_bench.sv
module sdh_irq_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic evt_rsp_done = 1'b0, evt_data_done = 1'b0, evt_ill_access = 1'b0;
    logic [6:0] err_evt = '0;
    logic rbuf_rdy = 1'b0, wbuf_rdy = 1'b0, dat0_lvl = 1'b0, cmd_busy = 1'b0, cd_raw = 1'b0;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdh_irq_status u_sdh_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_rsp_done(evt_rsp_done), .evt_data_done(evt_data_done),
        .err_evt(err_evt), .evt_ill_access(evt_ill_access),
        .rbuf_rdy(rbuf_rdy), .wbuf_rdy(wbuf_rdy), .dat0_lvl(dat0_lvl),
        .cmd_busy(cmd_busy), .cd_raw(cd_raw), .irq(irq)
    );

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    logic [31:0] v;

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1 reset values
        rd(2'd0, v); chk("R1 status A", v, 32'h0);
        rd(2'd1, v); chk("R1 mask A", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 status B", v, 32'h0);
        rd(2'd3, v); chk("R1 mask B", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 R4 R8: sweep each error pulse
        for (int i = 0; i < 7; i++) begin
            err_evt = 7'(1 << i); cyc(); err_evt = '0;
            rd(2'd2, v); chk("R3 error bit set", v, 32'(1 << i));
            chk("R8 masked irq", {31'b0, irq}, 32'h0);
            wr(2'd3, ~(32'(1 << i)));
            chk("R8 unmasked irq", {31'b0, irq}, 32'h1);
            wr(2'd3, 32'hFFFF_FFFF);
            wr(2'd2, ~(32'(1 << i)));
            rd(2'd2, v); chk("R4 clear by zero", v, 32'h0);
        end

        // R2 R4: status A sticky events, write-one keeps
        evt_rsp_done = 1'b1; evt_data_done = 1'b1; cyc();
        evt_rsp_done = 1'b0; evt_data_done = 1'b0;
        rd(2'd0, v); chk("R2 status A events", v, 32'h5);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R4 write one keeps", v, 32'h5);
        wr(2'd1, 32'hFFFF_FFFB);
        chk("R8 data-done unmasked", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'hFFFF_FFFB);
        chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R4 clear all A", v, 32'h0);

        // R3 illegal access bit 15
        evt_ill_access = 1'b1; cyc(); evt_ill_access = 1'b0;
        rd(2'd2, v); chk("R3 illegal access bit", v, 32'h8000);
        wr(2'd2, 32'h0);

        // R6 set beats clear
        evt_rsp_done = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0; reg_wr = 1'b1;
        cyc();
        evt_rsp_done = 1'b0; reg_wr = 1'b0;
        rd(2'd0, v); chk("R6 set wins", v, 32'h1);
        wr(2'd0, 32'h0);

        // R5 live bits
        dat0_lvl = 1'b1; cmd_busy = 1'b1; #1;
        rd(2'd2, v); chk("R5 live B", v, 32'h4080);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R5 live ignores write", v, 32'h4080);
        dat0_lvl = 1'b0; #1;
        rd(2'd2, v); chk("R5 live follows", v, 32'h4000);
        cmd_busy = 1'b0;

        // R7 buffer ready edges
        for (int b = 0; b < 2; b++) begin
            logic [31:0] bit_v;
            bit_v = (b == 0) ? 32'h100 : 32'h200;
            if (b == 0) rbuf_rdy = 1'b1; else wbuf_rdy = 1'b1;
            cyc();
            rd(2'd2, v); chk("R7 set on rise", v, bit_v);
            wr(2'd2, ~bit_v);
            cyc(3);
            rd(2'd2, v); chk("R7 no reset while high", v, 32'h0);
            if (b == 0) rbuf_rdy = 1'b0; else wbuf_rdy = 1'b0;
            cyc();
            rd(2'd2, v); chk("R7 no set on fall", v, 32'h0);
            if (b == 0) rbuf_rdy = 1'b1; else wbuf_rdy = 1'b1;
            cyc();
            rd(2'd2, v); chk("R7 set on second rise", v, bit_v);
            rbuf_rdy = 1'b0; wbuf_rdy = 1'b0;
            wr(2'd2, 32'h0);
        end

        // R10 mask readback
        wr(2'd1, 32'h1234_5678); rd(2'd1, v); chk("R10 mask A", v, 32'h1234_5678);
        wr(2'd3, 32'h8765_4321); rd(2'd3, v); chk("R10 mask B", v, 32'h8765_4321);
        wr(2'd1, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);

        // R9 glitch of three cycles
        cd_raw = 1'b1; cyc(3); cd_raw = 1'b0; cyc(10);
        rd(2'd0, v); chk("R9 glitch ignored", v, 32'h0);
        // R9 lasting rise: 7 edges
        cd_raw = 1'b1; cyc(6);
        rd(2'd0, v); chk("R9 insert not before 7", v, 32'h0);
        cyc();
        rd(2'd0, v); chk("R9 insert at 7", v, 32'h30);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R9 live present stays", v, 32'h20);
        cd_raw = 1'b0; cyc(3); cd_raw = 1'b1; cyc(10);
        rd(2'd0, v); chk("R9 removal glitch ignored", v, 32'h20);
        cd_raw = 1'b0; cyc(6);
        rd(2'd0, v); chk("R9 remove not before 7", v, 32'h20);
        cyc();
        rd(2'd0, v); chk("R9 remove at 7", v, 32'h08);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 reserved zero", v, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule